// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block picks which clock-gate and oscillator enables are active for one run state and five sleep levels. A four-bit control field, written the way a processor writes mode bits in its status word, selects the level. The block drives six enables: processor core, main clock, sub-system clock, auxiliary clock, the bias generator of the fast digitally controlled oscillator, and the crystal oscillator. The gate cells and oscillators themselves are outside the block.

A pending interrupt while asleep brings the block back to the run state so the handler can execute. The sleep bits are pushed into a one-deep save register when this happens, and a return-from-handler strobe pops them back, so the core goes back to sleep at the same level without software help. In sleep level 1 the bias generator stays on only if the fast oscillator drives the main or sub-system clock while running, which is signalled on a separate input.

Top module: `pm_clkgate_ctrl`

## Requirements
- R1: After reset the mode bits are 0000 and all six enables are 1.
- R2: Mode bit 0 is core-halt, bit 1 crystal-stop, bit 2 bias-off, bit 3 sub-clock-off. When bit 0 is 0 the block is running and all six enables are 1, whatever bits 3:1 hold.
- R3: Level 0 (0001): core and main clock off; sub-system clock, auxiliary clock, bias generator and crystal on.
- R4: Level 1 (0101): as level 0, except the bias generator is off when fast_osc_main is 0 and on when it is 1.
- R5: Level 2 (1001): core, main and sub-system clocks off; bias generator, auxiliary clock and crystal on.
- R6: Level 3 (1101): only the auxiliary clock and the crystal stay on.
- R7: Level 4 (1111): all six enables are 0.
- R8: A write accepted at a clock edge changes mode_bits and the enables at that same edge, so they are visible one cycle after the write is driven.
- R9: irq_pend while bit 0 is set clears the mode bits at the next edge (all enables on) and stores the previous bits in the save register.
- R10: irq_return while running copies the save register into the mode bits; it takes priority over a simultaneous write. The save register is 0000 after reset, so a return with nothing saved keeps the block running.
- R11: irq_pend while already running leaves the save register unchanged.
- R12: While bit 0 is set and no interrupt is pending, mode writes and return strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | Mode bits to write |
| irq_pend | input | 1 | An enabled interrupt is pending |
| irq_return | input | 1 | Handler return strobe |
| fast_osc_main | input | 1 | Fast oscillator sources main or sub clock when running |
| mode_bits | output | 4 | Current mode bits |
| core_en | output | 1 | Processor core enable |
| main_clk_en | output | 1 | Main clock gate enable |
| sub_clk_en | output | 1 | Sub-system clock gate enable |
| aux_clk_en | output | 1 | Auxiliary clock gate enable |
| dcgen_en | output | 1 | Fast oscillator bias generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The bench walks every sleep level through the wake and write path and checks the enable vector one cycle later; a decoder with a swapped bit would show the wrong clock running at exactly one level. Level 1 is visited with both settings of fast_osc_main, catching a design that ignores the conditional bias rule. A second interrupt while running, followed by a return, exposes a save register that is overwritten on nested wakes, and a return driven together with a write exposes wrong priority. Writes and returns sent while asleep must leave the mode untouched, which catches a design that acts on commands from a halted core.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int MODE_W = 4;
  localparam int EN_W   = 6;

  // Mode field, bit 3 down to bit 0
  typedef struct packed {
    logic sub_off;
    logic bias_off;
    logic xtal_stop;
    logic core_halt;
  } mode_t;

  typedef struct packed {
    logic core;
    logic main;
    logic sub;
    logic aux;
    logic dcgen;
    logic xtal;
  } en_t;

  localparam mode_t MODE_RUN = '0;
  localparam en_t   EN_ALL   = '1;

  // Map mode bits and the oscillator-use hint to the enable set
  function automatic en_t decode_enables(mode_t m, logic fast_used);
    en_t e;
    if (!m.core_halt) begin
      e = EN_ALL;
    end else begin
      e.core  = 1'b0;
      e.main  = 1'b0;
      e.sub   = !m.sub_off;
      e.aux   = !m.xtal_stop;
      e.xtal  = !m.xtal_stop;
      e.dcgen = !m.bias_off || (fast_used && !m.sub_off);
    end
    return e;
  endfunction
endpackage

// File: rtl/pm_mode_state.sv
module pm_mode_state
  import pm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  mode_t wdata,
  input  logic  irq,
  input  logic  ret,
  output mode_t mode_q,
  output mode_t mode_d,
  output logic  sleeping
);
  mode_t save_q, save_d;
  logic  wake_ev, ret_ev, wr_ev;

  assign sleeping = mode_q.core_halt;
  assign wake_ev  = irq && sleeping;
  assign ret_ev   = ret && !sleeping;
  assign wr_ev    = wr && !sleeping && !ret;

  always_comb begin
    mode_d = mode_q;
    save_d = save_q;
    if (wake_ev) begin
      save_d = mode_q;
      mode_d = MODE_RUN;
    end else if (ret_ev) begin
      mode_d = save_q;
    end else if (wr_ev) begin
      mode_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      save_q <= MODE_RUN;
    end else begin
      mode_q <= mode_d;
      save_q <= save_d;
    end
  end

  // R9
  wake_clears_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && sleeping) |=> (mode_q == MODE_RUN && save_q == $past(mode_q)));
  // R11
  nested_keeps_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !sleeping) |=> $stable(save_q));
  // R10
  return_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !sleeping) |=> (mode_q == $past(save_q)));
  // R12
  sleep_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !irq) |=> $stable(mode_q));
endmodule

// File: rtl/pm_enable_reg.sv
module pm_enable_reg
  import pm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_next,
  input  mode_t mode_now,
  input  logic  fast_used,
  output en_t   en_q
);
  en_t en_d;
  assign en_d = decode_enables(mode_next, fast_used);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= EN_ALL;
    else        en_q <= en_d;
  end

  // R2
  run_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_now.core_halt |-> (en_q == EN_ALL));
  // R7
  deep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 4'b1111) |-> (en_q == '0));
  // R3
  halt_stops_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_now.core_halt |-> (!en_q.core && !en_q.main));
endmodule

// File: rtl/pm_clkgate_ctrl.sv
module pm_clkgate_ctrl
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [3:0] mode_wdata,
  input  logic       irq_pend,
  input  logic       irq_return,
  input  logic       fast_osc_main,
  output logic [3:0] mode_bits,
  output logic       core_en,
  output logic       main_clk_en,
  output logic       sub_clk_en,
  output logic       aux_clk_en,
  output logic       dcgen_en,
  output logic       xtal_en
);
  mode_t mode_q, mode_d;
  logic  sleeping;
  en_t   en_q;

  pm_mode_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (mode_wr),
    .wdata    (mode_t'(mode_wdata)),
    .irq      (irq_pend),
    .ret      (irq_return),
    .mode_q   (mode_q),
    .mode_d   (mode_d),
    .sleeping (sleeping)
  );

  pm_enable_reg u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_next (mode_d),
    .mode_now  (mode_q),
    .fast_used (fast_osc_main),
    .en_q      (en_q)
  );

  assign mode_bits   = mode_q;
  assign core_en     = en_q.core;
  assign main_clk_en = en_q.main;
  assign sub_clk_en  = en_q.sub;
  assign aux_clk_en  = en_q.aux;
  assign dcgen_en    = en_q.dcgen;
  assign xtal_en     = en_q.xtal;
endmodule

// File: tb/pm_clkgate_ctrl_tb.sv
module pm_clkgate_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic mode_wr = 0, irq_pend = 0, irq_return = 0, fast_osc_main = 0;
  logic [3:0] mode_wdata = 0;
  logic [3:0] mode_bits;
  logic core_en, main_clk_en, sub_clk_en, aux_clk_en, dcgen_en, xtal_en;

  always #4 clk = ~clk;

  pm_clkgate_ctrl u_dut (.*);

  int errors = 0, checks = 0, cycles = 0;

  typedef struct { logic [3:0] mode; logic [5:0] en; string tag; } item_t;
  item_t q[$];

  logic [3:0] m_mode = 0, m_save = 0;

  // enable order: core main sub aux bias xtal
  function automatic logic [5:0] expect_en(logic [3:0] m, logic fast);
    case (m)
      4'b0001: return 6'b001111;
      4'b0101: return fast ? 6'b001111 : 6'b001101;
      4'b1001: return 6'b000111;
      4'b1101: return 6'b000101;
      4'b1111: return 6'b000000;
      default: return m[0] ? 6'bxxxxxx : 6'b111111;
    endcase
  endfunction

  task automatic step(input logic wr, input logic [3:0] d, input logic irq,
                      input logic ret, input logic fast, input string tag);
    item_t it;
    @(negedge clk);
    mode_wr = wr; mode_wdata = d; irq_pend = irq; irq_return = ret;
    fast_osc_main = fast;
    if (m_mode[0]) begin
      if (irq) begin m_save = m_mode; m_mode = 4'b0000; end
    end else if (ret) m_mode = m_save;
    else if (wr) m_mode = d;
    it.mode = m_mode; it.en = expect_en(m_mode, fast); it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      logic [5:0] got;
      it = q.pop_front();
      got = {core_en, main_clk_en, sub_clk_en, aux_clk_en, dcgen_en, xtal_en};
      checks++;
      if (got !== it.en || mode_bits !== it.mode) begin
        errors++;
        $display("FAIL %s: mode=%b en=%b expected mode=%b en=%b",
                 it.tag, mode_bits, got, it.mode, it.en);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (mode_bits !== 4'b0000 ||
        {core_en, main_clk_en, sub_clk_en, aux_clk_en, dcgen_en, xtal_en} !== 6'b111111) begin
      errors++;
      $display("FAIL R1: mode=%b en=%b expected mode=0000 en=111111", mode_bits,
               {core_en, main_clk_en, sub_clk_en, aux_clk_en, dcgen_en, xtal_en});
    end
    step(0, 4'h0, 0, 1, 0, "R10 empty save return");
    step(1, 4'b0001, 0, 0, 0, "R3 R8 level0");
    step(1, 4'b0101, 0, 0, 0, "R12 write while asleep");
    step(0, 4'h0, 1, 0, 0, "R9 wake");
    step(0, 4'h0, 0, 1, 0, "R10 return to level0");
    step(0, 4'h0, 1, 0, 0, "R9 wake again");
    step(0, 4'h0, 1, 0, 0, "R11 nested irq");
    step(1, 4'b1110, 0, 0, 0, "R2 run with upper bits");
    step(0, 4'h0, 0, 1, 0, "R11 save intact");
    step(0, 4'h0, 1, 0, 0, "R9 wake");
    step(1, 4'b0101, 0, 0, 0, "R4 level1 bias off");
    step(0, 4'h0, 1, 0, 1, "R9 wake");
    step(1, 4'b0101, 0, 0, 1, "R4 level1 bias on");
    step(0, 4'h0, 0, 0, 0, "R4 hint dropped");
    step(0, 4'h0, 1, 0, 0, "R9 wake");
    step(1, 4'b1001, 0, 0, 0, "R5 level2");
    step(0, 4'h0, 1, 0, 0, "R9 wake");
    step(1, 4'b1101, 0, 0, 0, "R6 level3");
    step(0, 4'h0, 1, 0, 0, "R9 wake");
    step(1, 4'b1111, 0, 0, 0, "R7 level4");
    step(0, 4'h0, 0, 1, 0, "R12 return while asleep");
    step(0, 4'h0, 1, 0, 0, "R9 wake from level4");
    step(1, 4'b0001, 0, 1, 0, "R10 return beats write");
    step(0, 4'h0, 0, 0, 0, "R7 level4 held");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule